// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for every beat of one burst access to a synchronous graphics DRAM. A start strobe captures a starting column, a burst length code, an ordering type and the read/write direction. From the next clock onward the block drives one column address per cycle, together with a valid flag. It also drives a last-beat flag that a memory controller can use to launch a self-timed auto precharge.

Bursts of 2, 4 and 8 wrap inside their aligned block of columns, in linear or interleaved order. A full-page burst walks the whole 256-column row and keeps wrapping until a stop or a new start ends it. A stop strobe cuts a burst short. When single-write mode is set, write bursts shrink to one beat while reads keep the programmed length. A new start during a burst abandons the old burst at once.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is asserted and until the first start, valid_o and last_o are low.
- R2: A start_i sampled high at a clock edge makes valid_o high in the following cycle, and col_o then equals the col_i sampled at that edge.
- R3: The length code bl_i selects 0→1, 1→2, 2→4, 3→8 and 7→full page beats; codes 4, 5 and 6 give one beat. An unstopped burst of length L keeps valid_o high for exactly L consecutive cycles.
- R4: Linear order (bt_i=0) with length L of 2, 4 or 8: beat k keeps the upper column bits of the start column, and its low log2(L) bits equal (start + k) mod L.
- R5: Interleaved order (bt_i=1) with length L of 2, 4 or 8: beat k is the start column XOR k.
- R6: A full-page burst gives start + k mod 256 for either bt_i value, wraps from 255 to 0, and stays valid until a stop or a new start.
- R7: last_o is high only together with valid_o, on the final beat of a burst of finite length, and never during a full-page burst. After a final beat with no new start, valid_o is low.
- R8: stop_i sampled during a burst makes valid_o low in the next cycle without a last_o pulse. stop_i sampled while idle has no effect.
- R9: With brsw_i=1, a write start (wr_i=1) gives a one-beat burst with last_o high on it. A read start (wr_i=0) keeps the programmed length.
- R10: A start during a burst abandons it, and the new burst's first beat appears in the next cycle. When start_i and stop_i are high together, the start wins.
- R11: col_i, bl_i, bt_i, brsw_i and wr_i are used only at a start. Changing them during a burst does not alter its addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new burst |
| wr_i | input | 1 | Direction of the starting burst: 1 write, 0 read |
| col_i | input | COL_W | Starting column |
| bl_i | input | 3 | Burst length code |
| bt_i | input | 1 | Ordering: 0 linear, 1 interleaved |
| brsw_i | input | 1 | Writes use a single beat |
| stop_i | input | 1 | Terminate the running burst |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | col_o holds a beat |
| last_o | output | 1 | Final beat of a finite burst |

## Verification
Three events can fall in the same cycle and compete: a start, a stop, and the natural final beat of a burst. The bench drives start_i and stop_i high together, both during a full-page burst and on the last beat of a short burst. The random phase also mixes independent start and stop strobes at moderate rates, so these collisions recur many times. Each cycle the outputs are compared with a bench model that gives the start priority, so any cycle where the stop or the completion wins shows up as a wrong valid_o or col_o.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic [2:0] {
    BLC_1    = 3'd0,
    BLC_2    = 3'd1,
    BLC_4    = 3'd2,
    BLC_8    = 3'd3,
    BLC_PAGE = 3'd7
  } blen_code_e;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } order_e;
endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [2:0]       bl_i,
  input  logic             brsw_i,
  input  logic             wr_i,
  output logic [COL_W-1:0] mask_o,
  output logic             full_o
);
  localparam logic [COL_W-1:0] PAGE_MASK = '1;

  logic single;
  logic [COL_W-1:0] mask_raw;

  assign single = brsw_i & wr_i;

  always_comb begin
    mask_raw = '0;
    case (bl_i)
      BLC_2:    mask_raw = COL_W'(1);
      BLC_4:    mask_raw = COL_W'(3);
      BLC_8:    mask_raw = COL_W'(7);
      BLC_PAGE: mask_raw = PAGE_MASK;
      default:  mask_raw = '0;
    endcase
  end

  assign mask_o = single ? '0 : mask_raw;
  assign full_o = !single && (bl_i == BLC_PAGE);
endmodule

// File: rtl/col_addr_gen.sv
module col_addr_gen #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             full_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] sum;
  logic [COL_W-1:0] lin;
  logic [COL_W-1:0] xr;

  assign sum = base_i + beat_i;
  // full page: mask is all ones, so lin degenerates to base + beat mod 2^COL_W
  assign lin = (base_i & ~mask_i) | (sum & mask_i);
  assign xr  = base_i ^ (beat_i & mask_i);

  always_comb begin
    if (full_i || !ilv_i) col_o = lin;
    else                  col_o = xr;
  end
endmodule

// File: rtl/beat_ctrl.sv
module beat_ctrl #(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             full_i,
  input  logic             ilv_i,
  output logic             active_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] mask_o,
  output logic             full_o,
  output logic             ilv_o,
  output logic [COL_W-1:0] beat_o,
  output logic             last_o
);
  localparam logic [COL_W-1:0] ONE = COL_W'(1);

  logic             active_q;
  logic [COL_W-1:0] base_q, mask_q, beat_q;
  logic             full_q, ilv_q;

  assign last_o = active_q && !full_q && (beat_q == mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      base_q   <= '0;
      mask_q   <= '0;
      beat_q   <= '0;
      full_q   <= 1'b0;
      ilv_q    <= 1'b0;
    end else if (start_i) begin
      active_q <= 1'b1;
      base_q   <= col_i;
      mask_q   <= mask_i;
      full_q   <= full_i;
      ilv_q    <= ilv_i;
      beat_q   <= '0;
    end else if (active_q) begin
      if (stop_i || last_o) active_q <= 1'b0;
      else                  beat_q   <= beat_q + ONE;
    end
  end

  assign active_o = active_q;
  assign base_o   = base_q;
  assign mask_o   = mask_q;
  assign full_o   = full_q;
  assign ilv_o    = ilv_q;
  assign beat_o   = beat_q;

  AST_START_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> active_q && (beat_q == '0)); // R10
  AST_STOP_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && stop_i && !start_i |=> !active_q); // R8
  AST_LAST_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o && !start_i |=> !active_q); // R7
  AST_BEAT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && !start_i && !stop_i && !last_o |=> active_q && (beat_q == $past(beat_q) + ONE)); // R3
  AST_HOLD_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && !start_i |=> $stable(base_q) && $stable(mask_q) && $stable(ilv_q)); // R11
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             wr_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [2:0]       bl_i,
  input  logic             bt_i,
  input  logic             brsw_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  localparam logic [COL_W-1:0] ONE = COL_W'(1);

  logic [COL_W-1:0] dec_mask;
  logic             dec_full;
  logic             active;
  logic [COL_W-1:0] base, mask, beat;
  logic             full, ilv, last;

  burst_len_decode #(.COL_W(COL_W)) u_dec (
    .bl_i   (bl_i),
    .brsw_i (brsw_i),
    .wr_i   (wr_i),
    .mask_o (dec_mask),
    .full_o (dec_full)
  );

  beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .stop_i   (stop_i),
    .col_i    (col_i),
    .mask_i   (dec_mask),
    .full_i   (dec_full),
    .ilv_i    (bt_i),
    .active_o (active),
    .base_o   (base),
    .mask_o   (mask),
    .full_o   (full),
    .ilv_o    (ilv),
    .beat_o   (beat),
    .last_o   (last)
  );

  col_addr_gen #(.COL_W(COL_W)) u_addr (
    .base_i (base),
    .beat_i (beat),
    .mask_i (mask),
    .full_i (full),
    .ilv_i  (ilv),
    .col_o  (col_o)
  );

  assign valid_o = active;
  assign last_o  = last;

  AST_FIRST_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o && (col_o == $past(col_i))); // R2
  AST_LAST_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o); // R7
  AST_BLOCK_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !full |-> ((col_o ^ base) & ~mask) == '0); // R4
  AST_PAGE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && full && !start_i && !stop_i |=> valid_o && (col_o == $past(col_o) + ONE)); // R6
  AST_PAGE_NO_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && full |-> !last_o); // R6
endmodule

// File: tb/burst_col_seq_tb.sv
`timescale 1ns/1ps
module burst_col_seq_tb;
  localparam int COL_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, wr = 0, bt = 0, brsw = 0, stop = 0;
  logic [COL_W-1:0] col = '0;
  logic [2:0] bl = '0;
  logic [COL_W-1:0] col_o;
  logic valid_o, last_o;

  int errors = 0, checks = 0;
  bit done = 0;

  // model state
  bit m_act = 0, m_full = 0, m_ilv = 0;
  logic [COL_W-1:0] m_base = '0, m_mask = '0, m_beat = '0;

  always #2 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .wr_i(wr), .col_i(col),
    .bl_i(bl), .bt_i(bt), .brsw_i(brsw), .stop_i(stop),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o));

  function automatic logic [COL_W-1:0] len_mask(logic [2:0] b, bit s, bit w);
    if (s && w) return '0;
    case (b)
      3'd1: return 8'd1;
      3'd2: return 8'd3;
      3'd3: return 8'd7;
      3'd7: return 8'hFF;
      default: return '0;
    endcase
  endfunction

  function automatic logic [COL_W-1:0] exp_col(logic [COL_W-1:0] b, logic [COL_W-1:0] k,
                                               logic [COL_W-1:0] m, bit f, bit x);
    logic [COL_W-1:0] s;
    s = b + k;
    if (f) return s;
    if (x) return b ^ k;
    return (b & ~m) | (s & m);
  endfunction

  task automatic chk(string req, logic [COL_W-1:0] act, logic [COL_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // check current outputs, then drive one cycle of stimulus and advance the model
  task automatic cyc(string tag, bit s, bit p, bit w, logic [COL_W-1:0] c,
                     logic [2:0] b, bit t, bit r);
    bit m_last;
    string rq;
    @(negedge clk);
    rq = (tag != "") ? tag : (m_full ? "R6" : (m_ilv ? "R5" : "R4"));
    m_last = m_act && !m_full && (m_beat == m_mask);
    chk({rq, " valid"}, 8'(valid_o), 8'(m_act));
    chk({rq, " last"}, 8'(last_o), 8'(m_last));
    if (m_act) chk({rq, " col"}, col_o, exp_col(m_base, m_beat, m_mask, m_full, m_ilv));
    start = s; stop = p; wr = w; col = c; bl = b; bt = t; brsw = r;
    if (s) begin
      m_act = 1; m_beat = '0; m_base = c; m_mask = len_mask(b, r, w);
      m_full = (b == 3'd7) && !(r && w); m_ilv = t;
    end else if (m_act) begin
      if (p || m_last) m_act = 0;
      else m_beat = m_beat + 8'd1;
    end
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) cyc(tag, 0, 0, 0, 8'h00, 3'd0, 0, 0);
  endtask

  initial begin
    int seed;
    seed = 32'h5EED_0042;
    void'($urandom(seed));
    repeat (3) begin
      @(negedge clk);
      chk("R1 reset valid", 8'(valid_o), 8'd0);
      chk("R1 reset last", 8'(last_o), 8'd0);
    end
    rst_n = 1'b1;
    idle("R1", 2);
    // R3/R4: linear 8 starting mid-block
    cyc("R2", 1, 0, 0, 8'h2D, 3'd3, 0, 0);
    idle("R4", 10);
    // R5: interleaved 4
    cyc("R2", 1, 0, 0, 8'h46, 3'd2, 1, 0);
    idle("R5", 6);
    // R3: reserved code gives one beat
    cyc("R3", 1, 0, 0, 8'h11, 3'd5, 0, 0);
    idle("R3", 3);
    // R6: full page wrap 254 -> 255 -> 0
    cyc("R6", 1, 0, 0, 8'hFE, 3'd7, 1, 0);
    idle("R6", 5);
    cyc("R8", 0, 1, 0, 8'h00, 3'd0, 0, 0);
    idle("R8", 2);
    // R8: stop while idle
    cyc("R8", 0, 1, 0, 8'h00, 3'd0, 0, 0);
    idle("R8", 2);
    // R9: single write, then read keeps length
    cyc("R9", 1, 0, 1, 8'h33, 3'd3, 0, 1);
    idle("R9", 3);
    cyc("R9", 1, 0, 0, 8'h33, 3'd2, 0, 1);
    idle("R9", 6);
    // R10: start with stop during full page, then on last beat of a short burst
    cyc("R10", 1, 0, 0, 8'h80, 3'd7, 0, 0);
    idle("R10", 3);
    cyc("R10", 1, 1, 0, 8'h19, 3'd1, 0, 0);
    cyc("R10", 0, 0, 0, 8'h00, 3'd0, 0, 0);
    cyc("R10", 1, 1, 0, 8'hC4, 3'd2, 1, 0);
    idle("R10", 6);
    // R11: inputs change mid burst
    cyc("R11", 1, 0, 0, 8'h05, 3'd3, 0, 0);
    for (int i = 0; i < 7; i++) cyc("R11", 0, 0, 1, 8'(i * 37), 3'(i), i[0], 1);
    idle("R7", 3);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit s, p;
      logic [2:0] b;
      int sel;
      s = ($urandom % 100) < 18;
      p = ($urandom % 100) < 6;
      sel = $urandom % 6;
      b = (sel == 4) ? 3'd7 : (sel == 5) ? 3'(4 + $urandom % 3) : 3'(sel);
      cyc("", s, p, 1'($urandom), 8'($urandom), b, 1'($urandom), 1'(($urandom % 4) == 0));
    end
    idle("R7", 4);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule